// File: doc/BRIEF.md
# PFC Protection and Enable Supervisor

This block sits between a set of already-digitised comparator flags and the switching sequencer of a boost power-factor-correction stage. It decides whether the sequencer may run. Each flag reports one threshold crossing: supply rising past its turn-on level, supply falling past its turn-off level, supply overvoltage, feedback overvoltage, feedback open-loop undervoltage, line above its brown-in level, line below its brown-out level, the zero-current pin pulled low for standby, the zero-current pin released, and the error-amplifier output below or above the light-load band.

Paired flags feed hysteresis state machines. A state changes only on its own debounced flag, and holds while neither flag of its pair is asserted. Single-ended fault flags go through debounce timers. A fault stops switching while it persists, and switching returns by itself once the fault clears. A separate burst state asks the sequencer to pause switching under light load. The burst state leaves the enable decision and the stop record untouched. A three-bit stop-cause word holds the reason for the most recent stop until switching is enabled again.

All debounce windows are parameters counted in clock cycles. The defaults assume a 50 MHz clock: 10 µs for supply overvoltage, 20 µs for feedback faults, 80 µs for line detection and 2 µs for burst transitions.

Top module: `pfc_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `run_enable` and `burst_pause` are 0 and `stop_cause` is 0 (none). All hysteresis states reset to their inactive side: supply locked out, line not qualified, standby active, not paused.
- R2: The supply lockout releases one edge after `vdd_above_on` is sampled high and engages one edge after `vdd_below_off` is sampled high. With neither flag high, it keeps its state. `run_enable` follows the lockout one edge later, so a lockout on the first sampled `vdd_below_off` drops `run_enable` after the third edge.
- R3: `vdd_over` stops switching only after it has been sampled high on VDD_OV_CYC consecutive edges. `run_enable` falls one edge after that.
- R4: `fb_over` and `fb_under` each stop switching after FB_CYC consecutive high samples. `run_enable` falls one edge after that, at edge FB_CYC+1.
- R5: The line state qualifies after BROWN_CYC consecutive samples of `line_above_in` and disqualifies after BROWN_CYC consecutive samples of `line_below_out`. The state changes one edge after the count completes, and `run_enable` changes one edge after the state. While the supply lockout is engaged, the line state is forced unqualified and both of its counters are held at zero.
- R6: Standby is entered after ZC_CYC consecutive samples of `zc_below_dis` and left after ZC_CYC consecutive samples of `zc_above_en`. It holds with neither flag high.
- R7: `run_enable` is a register that is set when the lockout is released, the line is qualified, standby is off and no debounced fault is present. Recovery needs no action beyond the conditions clearing.
- R8: `burst_pause` rises BURST_CYC+1 edges after `comp_below_lo` is first sampled. It falls after BURST_CYC+1 edges of `comp_above_hi` and holds with neither flag high. It changes neither `run_enable` nor `stop_cause`.
- R9: When `run_enable` falls, `stop_cause` records the highest-priority failing condition, with the highest priority first: 1 supply lockout, 2 supply overvoltage, 3 feedback overvoltage, 4 feedback undervoltage, 5 line not qualified, 6 standby. The value holds while `run_enable` stays low and returns to 0 on the edge where `run_enable` rises.
- R10: Every debounce count restarts from zero as soon as its flag is sampled low before the count completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vdd_above_on | input | 1 | Supply above turn-on level |
| vdd_below_off | input | 1 | Supply below turn-off level |
| vdd_over | input | 1 | Supply overvoltage |
| fb_over | input | 1 | Feedback overvoltage |
| fb_under | input | 1 | Feedback below open-loop level |
| line_above_in | input | 1 | Line sense above brown-in level |
| line_below_out | input | 1 | Line sense below brown-out level |
| zc_below_dis | input | 1 | Zero-current pin held low (standby request) |
| zc_above_en | input | 1 | Zero-current pin released |
| comp_below_lo | input | 1 | Error-amp output below burst entry level |
| comp_above_hi | input | 1 | Error-amp output above burst exit level |
| run_enable | output | 1 | Switching permitted |
| burst_pause | output | 1 | Light-load pause request |
| stop_cause | output | 3 | Reason for the last stop (R9 encoding) |

## Verification
The bench measures each debounce window to the exact edge. A timer that is off by one would release `run_enable` a cycle early or late. A counter that freezes instead of clearing when its flag drops (R10) would trip on the interrupted feedback pulse. The bench leaves every flag quiet between operations, which catches a hysteresis state that decays instead of holding. It re-applies supply without a fresh line qualification, which catches a line state that survives a lockout. It overlaps faults to test the cause priority. While paused, it checks that `run_enable` and `stop_cause` stay undisturbed.

// File: rtl/pfc_guard_pkg.sv
// Shared types for the PFC supervisor: stop-cause encoding and its
// priority selection. Assumes at most one cause is reported per stop.
package pfc_guard_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE        = 3'd0,
        CAUSE_SUPPLY_LOW  = 3'd1,
        CAUSE_SUPPLY_HIGH = 3'd2,
        CAUSE_FB_HIGH     = 3'd3,
        CAUSE_FB_LOW      = 3'd4,
        CAUSE_LINE_LOW    = 3'd5,
        CAUSE_STANDBY     = 3'd6
    } stop_cause_e;

    // Highest-priority failing condition, supply lockout first.
    function automatic stop_cause_e pick_cause(
        input logic supply_low,
        input logic supply_high,
        input logic fb_high,
        input logic fb_low,
        input logic line_low,
        input logic standby
    );
        if (supply_low)       return CAUSE_SUPPLY_LOW;
        else if (supply_high) return CAUSE_SUPPLY_HIGH;
        else if (fb_high)     return CAUSE_FB_HIGH;
        else if (fb_low)      return CAUSE_FB_LOW;
        else if (line_low)    return CAUSE_LINE_LOW;
        else if (standby)     return CAUSE_STANDBY;
        else                  return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/pfc_guard_debounce.sv
// Persistence filter: held goes high after in_flag has been sampled high
// on LEN consecutive edges, and drops on the edge after in_flag is low.
// Any low sample clears the count. Assumes LEN >= 1.
module pfc_guard_debounce #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_flag,
    output logic held
);
    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    // Count consecutive high samples; saturate once the window is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            held <= 1'b0;
        end else if (!in_flag) begin
            cnt  <= '0;
            held <= 1'b0;
        end else if (cnt == LAST) begin
            held <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pfc_guard_hyst.sv
// Two-threshold state holder. The state sets on a debounced rise flag and
// clears on a debounced fall flag. The fall flag wins a tie. force_off
// clears the state and holds both filters idle. Assumes the rise and fall
// flags are normally exclusive.
module pfc_guard_hyst #(
    parameter int unsigned RISE_LEN = 4,
    parameter int unsigned FALL_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_off,
    input  logic rise_flag,
    input  logic fall_flag,
    output logic state
);
    logic rise_held;
    logic fall_held;

    pfc_guard_debounce #(.LEN(RISE_LEN)) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_flag (rise_flag & ~force_off),
        .held    (rise_held)
    );

    pfc_guard_debounce #(.LEN(FALL_LEN)) u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_flag (fall_flag & ~force_off),
        .held    (fall_held)
    );

    // Move the state only on a completed window; otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     state <= 1'b0;
        else if (force_off | fall_held) state <= 1'b0;
        else if (rise_held)             state <= 1'b1;
    end
endmodule

// File: rtl/pfc_guard_status.sv
// Output register for the run decision and the stop-cause record. The
// cause is captured on a run->stop transition and cleared on stop->run.
module pfc_guard_status
    import pfc_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_req,
    input  stop_cause_e reason,
    output logic        run_q,
    output stop_cause_e cause_q
);
    // Register run_req and keep the cause of the latest stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            run_q <= run_req;
            if (!run_q && run_req)      cause_q <= CAUSE_NONE;
            else if (run_q && !run_req) cause_q <= reason;
        end
    end
endmodule

// File: rtl/pfc_guard.sv
// PFC protection and enable supervisor. It combines digitised threshold
// flags into a run enable, a light-load pause request and a stop-cause
// record. Assumes all flags are synchronous to clk. Windows are in cycles.
module pfc_guard
    import pfc_guard_pkg::*;
#(
    parameter int unsigned VDD_OV_CYC = 500,
    parameter int unsigned FB_CYC     = 1000,
    parameter int unsigned BROWN_CYC  = 4000,
    parameter int unsigned BURST_CYC  = 100,
    parameter int unsigned ZC_CYC     = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vdd_above_on,
    input  logic       vdd_below_off,
    input  logic       vdd_over,
    input  logic       fb_over,
    input  logic       fb_under,
    input  logic       line_above_in,
    input  logic       line_below_out,
    input  logic       zc_below_dis,
    input  logic       zc_above_en,
    input  logic       comp_below_lo,
    input  logic       comp_above_hi,
    output logic       run_enable,
    output logic       burst_pause,
    output logic [2:0] stop_cause
);
    localparam int unsigned SUPPLY_CYC = 1;
    localparam int unsigned N_FAULT    = 3;
    localparam int unsigned FAULT_LEN [N_FAULT] = '{VDD_OV_CYC, FB_CYC, FB_CYC};

    logic               supply_ok;
    logic               line_ok;
    logic               zc_ok;
    logic [N_FAULT-1:0] fault_raw;
    logic [N_FAULT-1:0] fault_held;
    logic               run_req;
    stop_cause_e        reason;
    stop_cause_e        cause_q;

    // Supply lockout: set on the turn-on flag, cleared on the turn-off flag.
    pfc_guard_hyst #(.RISE_LEN(SUPPLY_CYC), .FALL_LEN(SUPPLY_CYC)) u_supply (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_off (1'b0),
        .rise_flag (vdd_above_on),
        .fall_flag (vdd_below_off),
        .state     (supply_ok)
    );

    // Line qualification, only evaluated while the supply is released.
    pfc_guard_hyst #(.RISE_LEN(BROWN_CYC), .FALL_LEN(BROWN_CYC)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_off (~supply_ok),
        .rise_flag (line_above_in),
        .fall_flag (line_below_out),
        .state     (line_ok)
    );

    // External standby through the zero-current pin.
    pfc_guard_hyst #(.RISE_LEN(ZC_CYC), .FALL_LEN(ZC_CYC)) u_zc (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_off (1'b0),
        .rise_flag (zc_above_en),
        .fall_flag (zc_below_dis),
        .state     (zc_ok)
    );

    // Light-load pause: entered on a low error-amp, left on a high one.
    pfc_guard_hyst #(.RISE_LEN(BURST_CYC), .FALL_LEN(BURST_CYC)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_off (1'b0),
        .rise_flag (comp_below_lo),
        .fall_flag (comp_above_hi),
        .state     (burst_pause)
    );

    assign fault_raw = {fb_under, fb_over, vdd_over};

    // One persistence filter per non-latching fault source.
    for (genvar gi = 0; gi < N_FAULT; gi++) begin : g_fault
        pfc_guard_debounce #(.LEN(FAULT_LEN[gi])) u_db (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_flag (fault_raw[gi]),
            .held    (fault_held[gi])
        );
    end

    // Combine all permissive conditions and rank the failing ones.
    always_comb begin
        run_req = supply_ok & line_ok & zc_ok & ~(|fault_held);
        reason  = pick_cause(~supply_ok, fault_held[0], fault_held[1],
                             fault_held[2], ~line_ok, ~zc_ok);
    end

    pfc_guard_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_req (run_req),
        .reason  (reason),
        .run_q   (run_enable),
        .cause_q (cause_q)
    );

    assign stop_cause = cause_q;
endmodule

// File: rtl/pfc_guard_chk.sv
// Temporal checks on the supervisor's ports, bound into every pfc_guard.
module pfc_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vdd_below_off,
    input logic       comp_below_lo,
    input logic       run_enable,
    input logic       burst_pause,
    input logic [2:0] stop_cause
);
    // R2: a turn-off sample three edges back forces the enable low.
    assert_lockout_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vdd_below_off, 3) |-> !run_enable);

    // R8: a pause can only start after a low error-amp sample.
    assert_pause_needs_low_comp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_pause) |-> $past(comp_below_lo, 2));

    // R9: no cause is reported while running.
    assert_cause_clear_while_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_enable |-> (stop_cause == 3'd0));

    // R9: every stop records a reason.
    assert_stop_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_enable) |-> (stop_cause != 3'd0));

    // R9: the record changes only on run transitions.
    assert_cause_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$fell(run_enable) && !$rose(run_enable)) |-> $stable(stop_cause));
endmodule

bind pfc_guard pfc_guard_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vdd_below_off (vdd_below_off),
    .comp_below_lo (comp_below_lo),
    .run_enable    (run_enable),
    .burst_pause   (burst_pause),
    .stop_cause    (stop_cause)
);

// File: tb/pfc_guard_tb.sv
// Self-checking bench: a vector table of steady states, then directed
// timing, restart, priority and reset tests.
module pfc_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 21;

    // Flag order: [10]vdd_on [9]vdd_off [8]vdd_ov [7]fb_ov [6]fb_uv
    // [5]line_in [4]line_out [3]zc_dis [2]zc_en [1]comp_lo [0]comp_hi
    // Vector: {flags, hold cycles, run, pause, cause}
    localparam logic [23:0] VEC [NVEC] = '{
        {11'b10000100101, 8'd20, 1'b1, 1'b0, 3'd0}, // 0  power-up R2 R5 R6 R7
        {11'b00000000000, 8'd20, 1'b1, 1'b0, 3'd0}, // 1  all hold R2 R5 R6
        {11'b00010000000, 8'd20, 1'b0, 1'b0, 3'd3}, // 2  fb over R4 R9
        {11'b00000000000, 8'd20, 1'b1, 1'b0, 3'd0}, // 3  recover R7 R9
        {11'b00001000000, 8'd20, 1'b0, 1'b0, 3'd4}, // 4  fb under R4 R9
        {11'b00000000000, 8'd20, 1'b1, 1'b0, 3'd0}, // 5  recover R7
        {11'b00100000000, 8'd20, 1'b0, 1'b0, 3'd2}, // 6  supply over R3 R9
        {11'b00000000000, 8'd20, 1'b1, 1'b0, 3'd0}, // 7  recover R3 R7
        {11'b00000000010, 8'd20, 1'b1, 1'b1, 3'd0}, // 8  burst in R8
        {11'b00000000000, 8'd20, 1'b1, 1'b1, 3'd0}, // 9  burst hold R8
        {11'b00000000001, 8'd20, 1'b1, 1'b0, 3'd0}, // 10 burst out R8
        {11'b00000001000, 8'd20, 1'b0, 1'b0, 3'd6}, // 11 standby R6 R9
        {11'b00000000000, 8'd20, 1'b0, 1'b0, 3'd6}, // 12 standby hold R6
        {11'b00000000100, 8'd20, 1'b1, 1'b0, 3'd0}, // 13 released R6
        {11'b00000010000, 8'd20, 1'b0, 1'b0, 3'd5}, // 14 brown-out R5
        {11'b00000100000, 8'd20, 1'b1, 1'b0, 3'd0}, // 15 brown-in R5
        {11'b01000000000, 8'd20, 1'b0, 1'b0, 3'd1}, // 16 lockout R2 R9
        {11'b10000000000, 8'd20, 1'b0, 1'b0, 3'd1}, // 17 supply back, line lost R5
        {11'b00000100000, 8'd20, 1'b1, 1'b0, 3'd0}, // 18 brown-in again R5
        {11'b00110000000, 8'd20, 1'b0, 1'b0, 3'd2}, // 19 two faults R9 priority
        {11'b00000000000, 8'd20, 1'b1, 1'b0, 3'd0}  // 20 recover R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] fl = '0;
    logic        run_enable;
    logic        burst_pause;
    logic [2:0]  stop_cause;
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done_run = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pfc_guard #(
        .VDD_OV_CYC (4),
        .FB_CYC     (5),
        .BROWN_CYC  (8),
        .BURST_CYC  (3),
        .ZC_CYC     (2)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .vdd_above_on   (fl[10]),
        .vdd_below_off  (fl[9]),
        .vdd_over       (fl[8]),
        .fb_over        (fl[7]),
        .fb_under       (fl[6]),
        .line_above_in  (fl[5]),
        .line_below_out (fl[4]),
        .zc_below_dis   (fl[3]),
        .zc_above_en    (fl[2]),
        .comp_below_lo  (fl[1]),
        .comp_above_hi  (fl[0]),
        .run_enable     (run_enable),
        .burst_pause    (burst_pause),
        .stop_cause     (stop_cause)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        @(negedge clk);
        step(3);
        check("R1 reset run_enable", run_enable, 0);
        check("R1 reset burst_pause", burst_pause, 0);
        check("R1 reset stop_cause", stop_cause, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            fl = VEC[v][23:13];
            step(int'(VEC[v][12:5]));
            check($sformatf("R7 run_enable vec%0d", v), run_enable, VEC[v][4]);
            check($sformatf("R8 burst_pause vec%0d", v), burst_pause, VEC[v][3]);
            check($sformatf("R9 stop_cause vec%0d", v), stop_cause, VEC[v][2:0]);
        end

        // R10 and R4: an interrupted feedback pulse restarts its count.
        fl = 11'b00010000000;
        step(4);
        fl = '0;
        step(1);
        fl = 11'b00010000000;
        step(4);
        check("R10 restarted count keeps run", run_enable, 1);
        step(1);
        check("R4 window met, output not yet", run_enable, 1);
        step(1);
        check("R4 run drops at FB_CYC+1", run_enable, 0);
        check("R4 cause fb over", stop_cause, 3);
        fl = '0;
        step(20);

        // R5: exact brown-in latency.
        fl = 11'b00000010000;
        step(20);
        check("R5 brown-out stop", run_enable, 0);
        fl = 11'b00000100000;
        step(9);
        check("R5 brown-in not yet", run_enable, 0);
        step(1);
        check("R5 brown-in at BROWN_CYC+2", run_enable, 1);
        fl = '0;

        // R8: exact pause latency, run untouched.
        fl = 11'b00000000010;
        step(3);
        check("R8 pause not yet", burst_pause, 0);
        step(1);
        check("R8 pause at BURST_CYC+1", burst_pause, 1);
        check("R8 pause keeps run", run_enable, 1);
        check("R8 pause keeps cause", stop_cause, 0);
        fl = 11'b00000000001;
        step(20);
        check("R8 pause released", burst_pause, 0);

        // R2: lockout latency.
        fl = 11'b01000000000;
        step(2);
        check("R2 lockout not yet", run_enable, 1);
        step(1);
        check("R2 lockout at third edge", run_enable, 0);
        check("R2 cause supply low", stop_cause, 1);

        // R3: supply overvoltage window.
        fl = 11'b10000100100;
        step(20);
        check("R2 R5 restart after lockout", run_enable, 1);
        fl = 11'b00100000000;
        step(4);
        check("R3 supply over not yet", run_enable, 1);
        step(1);
        check("R3 supply over stop", run_enable, 0);
        fl = '0;
        step(20);

        // R1: reset while running.
        rst_n = 1'b0;
        step(2);
        check("R1 mid-run reset run", run_enable, 0);
        check("R1 mid-run reset cause", stop_cause, 0);
        rst_n = 1'b1;
        step(20);
        check("R1 lockout after reset", run_enable, 0);

        finish_run();
    end
endmodule